// File: doc/BRIEF.md
# Mode-Banked Integer Register Index Flattener

This combinational unit converts a logical integer-register index, as seen by an instruction, into the index of an entry in a flat physical register file that holds every mode's banked copies. Its inputs are the logical index and the current processor mode. Its outputs are the physical index and an error flag.

The logical index space has three ranges. Indices 0 to 15 are architectural registers. They are translated through the bank map of the current mode. Indices 16 to 32 name physical banked entries directly and are returned unchanged. Indices of 33 and above carry an explicit mode in bits 9:5 and a register offset in bits 4:0. Such an index reaches a chosen mode's bank no matter which mode is current. The index input is 11 bits wide and read as two's complement, so bit 10 set means a negative index.

Physical layout: entries 0 to 15 hold the user copies of R0 to R15. Entries 16 to 22 hold the fast-interrupt copies of R8 to R14. Entries 23 to 32 hold the R13/R14 pairs of the interrupt, supervisor, monitor, abort and undefined modes, in that order.

Top module: `regidx_flatten`

## Requirements
- R1: The physical index output is never above 32, for any input combination.
- R2: Mode codes are user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, monitor 0x16, abort 0x17, undefined 0x1B and system 0x1F. For logical indices 0 to 15 and any of these modes, registers 0 to 7 and 15 map to the same physical number, with no error.
- R3: In fast-interrupt mode, logical 8 to 14 map to physical 16 to 22 in order.
- R4: Logical 13 and 14 map to 23 and 24 in interrupt mode, 25 and 26 in supervisor mode, 27 and 28 in monitor mode, 29 and 30 in abort mode, and 31 and 32 in undefined mode. In these modes, logical 8 to 12 map to themselves. User and system mode map every architectural register to itself.
- R5: Logical indices 16 to 32 come out unchanged with no error, whatever the current mode.
- R6: A logical index of 33 or more takes its mode from bits 9:5 and its register from bits 4:0, and maps exactly as the low range would in that mode. The current mode has no effect.
- R7: An explicit index raises the error flag when its mode field is not one of the eight codes in R2, or when its offset is 16 or more.
- R8: An index with bit 10 set is negative. It raises the error flag. Whenever the error flag is high, the physical index is 0.
- R9: A logical index of 0 to 15 with a current mode outside the eight codes of R2 raises the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lidx_i | input | 11 | Logical index, two's complement |
| mode_i | input | 5 | Current processor mode code |
| pidx_o | output | 6 | Physical register-file index |
| err_o | output | 1 | Index cannot be resolved |

## Verification
Both outputs are purely combinational, so each result is due in the same cycle that the index and mode are applied, with no register in the path. The bench drives a new input on the falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. Each check therefore sees the fully settled response to exactly one stimulus.

// File: rtl/regidx_flatten.sv
module regidx_flatten #(
  parameter int ARCH_REGS = 16,
  parameter int SLOT_REGS = 32,
  parameter int MODE_W    = 5,
  parameter int PHYS_W    = 6
) (
  input  logic [MODE_W+$clog2(SLOT_REGS):0] lidx_i,
  input  logic [MODE_W-1:0]                 mode_i,
  output logic [PHYS_W-1:0]                 pidx_o,
  output logic                              err_o
);
  localparam int SLOT_W = $clog2(SLOT_REGS);
  localparam int MAG_W  = MODE_W + SLOT_W;
  localparam int FIQ_BASE  = ARCH_REGS;
  localparam int PAIR_BASE = FIQ_BASE + 7;
  localparam int TOTAL     = PAIR_BASE + 10;

  localparam logic [MODE_W-1:0] M_USR = MODE_W'(5'h10);
  localparam logic [MODE_W-1:0] M_FIQ = MODE_W'(5'h11);
  localparam logic [MODE_W-1:0] M_IRQ = MODE_W'(5'h12);
  localparam logic [MODE_W-1:0] M_SVC = MODE_W'(5'h13);
  localparam logic [MODE_W-1:0] M_MON = MODE_W'(5'h16);
  localparam logic [MODE_W-1:0] M_ABT = MODE_W'(5'h17);
  localparam logic [MODE_W-1:0] M_UND = MODE_W'(5'h1B);
  localparam logic [MODE_W-1:0] M_SYS = MODE_W'(5'h1F);

  wire              negative = lidx_i[MAG_W];
  wire [MAG_W-1:0]  mag      = lidx_i[MAG_W-1:0];
  wire [MODE_W-1:0] xmode    = mag[MAG_W-1:SLOT_W];
  wire [SLOT_W-1:0] xoff     = mag[SLOT_W-1:0];

  function automatic logic [PHYS_W:0] remap(input logic [MODE_W-1:0] m,
                                            input logic [SLOT_W-1:0] r);
    int pair;
    logic ok;
    logic [PHYS_W-1:0] p;
    p    = PHYS_W'(r);
    ok   = 1'b1;
    pair = -1;
    case (m)
      M_USR, M_SYS: ;
      M_FIQ: if (r >= 8 && r <= 14) p = PHYS_W'(FIQ_BASE + int'(r) - 8);
      M_IRQ: pair = 0;
      M_SVC: pair = 1;
      M_MON: pair = 2;
      M_ABT: pair = 3;
      M_UND: pair = 4;
      default: ok = 1'b0;
    endcase
    if (pair >= 0 && (r == 13 || r == 14))
      p = PHYS_W'(PAIR_BASE + 2 * pair + int'(r) - 13);
    return {ok, p};
  endfunction

  logic [PHYS_W:0] res;

  always_comb begin
    res = '0;
    if (negative)
      res = '0;
    else if (int'(mag) < ARCH_REGS)
      res = remap(mode_i, xoff);
    else if (int'(mag) < TOTAL)
      res = {1'b1, PHYS_W'(mag)};
    else if (int'(xoff) < ARCH_REGS)
      res = remap(xmode, xoff);
  end

  assign err_o  = ~res[PHYS_W];
  assign pidx_o = err_o ? '0 : res[PHYS_W-1:0];
endmodule

// File: rtl/regidx_flatten_chk.sv
module regidx_flatten_chk (
  input logic [10:0] lidx_i,
  input logic [4:0]  mode_i,
  input logic [5:0]  pidx_o,
  input logic        err_o
);
  function automatic logic known(input logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1B, 5'h1F};
  endfunction

  always_comb begin
    AST_PHYS_BOUND: assert (pidx_o <= 6'd32); // R1
    if (!lidx_i[10] && lidx_i[9:0] < 10'd8 && known(mode_i))
      AST_SHARED_LOW: assert (!err_o && pidx_o == 6'(lidx_i[2:0])); // R2
    if (!lidx_i[10] && lidx_i[9:0] >= 10'd16 && lidx_i[9:0] <= 10'd32)
      AST_PASS_THRU: assert (!err_o && pidx_o == lidx_i[5:0]); // R5
    if (!lidx_i[10] && lidx_i[9:0] >= 10'd33 && !known(lidx_i[9:5]))
      AST_BAD_XMODE: assert (err_o); // R7
    if (lidx_i[10])
      AST_NEG_ERR: assert (err_o); // R8
    if (err_o)
      AST_ERR_ZERO: assert (pidx_o == 6'd0); // R8
    if (!lidx_i[10] && lidx_i[9:0] < 10'd16 && !known(mode_i))
      AST_BAD_CUR_MODE: assert (err_o); // R9
  end
endmodule

bind regidx_flatten regidx_flatten_chk u_chk (
  .lidx_i(lidx_i), .mode_i(mode_i), .pidx_o(pidx_o), .err_o(err_o)
);

// File: tb/regidx_flatten_tb.sv
`timescale 1ns/1ps
module regidx_flatten_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [10:0] lidx;
  logic [4:0]  mode;
  logic [5:0]  pidx;
  logic        err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  regidx_flatten u_dut (.lidx_i(lidx), .mode_i(mode), .pidx_o(pidx), .err_o(err));

  // {index, current mode, expected phys, expected err}
  localparam int NV = 25;
  localparam logic [22:0] VEC [NV] = '{
    {11'd3,    5'h10, 6'd3,  1'b0}, // R2
    {11'd8,    5'h11, 6'd16, 1'b0}, // R3
    {11'd14,   5'h11, 6'd22, 1'b0}, // R3
    {11'd13,   5'h12, 6'd23, 1'b0}, // R4
    {11'd14,   5'h13, 6'd26, 1'b0}, // R4
    {11'd13,   5'h16, 6'd27, 1'b0}, // R4
    {11'd14,   5'h17, 6'd30, 1'b0}, // R4
    {11'd13,   5'h1B, 6'd31, 1'b0}, // R4
    {11'd13,   5'h1F, 6'd13, 1'b0}, // R4
    {11'd15,   5'h11, 6'd15, 1'b0}, // R2
    {11'd10,   5'h12, 6'd10, 1'b0}, // R4
    {11'd5,    5'h05, 6'd0,  1'b1}, // R9
    {11'd20,   5'h10, 6'd20, 1'b0}, // R5
    {11'd32,   5'h17, 6'd32, 1'b0}, // R5
    {11'd20,   5'h00, 6'd20, 1'b0}, // R5
    {11'd553,  5'h10, 6'd17, 1'b0}, // R6
    {11'd878,  5'h10, 6'd32, 1'b0}, // R6
    {11'd1005, 5'h11, 6'd13, 1'b0}, // R6
    {11'd589,  5'h11, 6'd23, 1'b0}, // R6
    {11'd642,  5'h10, 6'd0,  1'b1}, // R7
    {11'd532,  5'h10, 6'd0,  1'b1}, // R7
    {11'd33,   5'h10, 6'd0,  1'b1}, // R7
    {11'd100,  5'h10, 6'd0,  1'b1}, // R7
    {11'h7FF,  5'h10, 6'd0,  1'b1}, // R8
    {11'h400,  5'h11, 6'd0,  1'b1}  // R8
  };

  task automatic apply(input logic [10:0] i, input logic [4:0] m);
    @(negedge clk);
    lidx = i;
    mode = m;
    #1;
  endtask

  task automatic check(input logic [5:0] ep, input logic ee, input string tag);
    checks++;
    if (pidx !== ep || err !== ee) begin
      errors++;
      $display("FAIL %s idx=%0d mode=%h: got phys=%0d err=%0b, expected phys=%0d err=%0b",
               tag, lidx, mode, pidx, err, ep, ee);
    end
  endtask

  initial begin
    lidx = '0;
    mode = 5'h10;
    #1;
    check(6'd0, 1'b0, "R2 initial state");

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][22:12], VEC[v][11:7]);
      check(VEC[v][6:1], VEC[v][0], "R2-R9 vector");
    end

    for (int k = 0; k < 8; k++) begin
      logic [4:0] m;
      m = (k == 0) ? 5'h10 : (k == 1) ? 5'h11 : (k == 2) ? 5'h12 : (k == 3) ? 5'h13 :
          (k == 4) ? 5'h16 : (k == 5) ? 5'h17 : (k == 6) ? 5'h1B : 5'h1F;
      for (int r = 0; r < 8; r++) begin
        apply(11'(r), m);
        check(6'(r), 1'b0, "R2 shared low");
      end
      apply(11'd15, m);
      check(6'd15, 1'b0, "R2 shared r15");
      apply(11'(512 + 32 * (k == 7 ? 15 : 0) + (k == 7 ? 0 : 0)), 5'h00);
    end

    for (int r = 8; r <= 14; r++) begin
      apply(11'(r), 5'h11);
      check(6'(16 + r - 8), 1'b0, "R3 fiq bank");
      apply(11'(17 * 32 + r), 5'h10);
      check(6'(16 + r - 8), 1'b0, "R6 explicit fiq");
    end

    for (int r = 16; r <= 32; r++) begin
      apply(11'(r), 5'(r * 3));
      check(6'(r), 1'b0, "R5 pass-through");
    end

    apply(11'(16 * 32 + 16), 5'h10);
    check(6'd0, 1'b1, "R7 offset 16");
    apply(11'(27 * 32 + 14), 5'h07);
    check(6'd32, 1'b0, "R6 explicit ignores bad current mode");
    apply(11'd15, 5'h1C);
    check(6'd0, 1'b1, "R9 bad current mode r15");

    for (int i = 0; i < 2048; i++) begin
      apply(11'(i), 5'(i));
      checks++;
      if (pidx > 6'd32 || (err && pidx != 6'd0)) begin
        errors++;
        $display("FAIL R1 idx=%0d: got phys=%0d err=%0b, expected phys<=32 and 0 on error",
                 i, pidx, err);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule